// File: doc/BRIEF.md
# DMA Channel Trigger Queue Controller

This block accepts trigger requests for a bank of DMA channels and converts them into transfer-request submissions for a downstream transfer engine. Each channel has two trigger sources. One is a hardware event line. The other is a software set strobe. A hardware event is held in a per-channel pending bit and is served only while the channel's enable bit is set. A software set is served whatever the enable state.

Eligible channels go into a channel-number FIFO, one per cycle, lowest number first. The FIFO head is checked against a per-channel null-descriptor flag. If the descriptor is valid, the channel number is offered on a valid/ready handshake. If it is null, the trigger is discarded and the channel's missed-event bit is set.

A trigger that arrives while the same channel's earlier trigger is still pending, queued or waiting at the head is not queued a second time. It is recorded as a missed event instead. Software manages the enable bits and clears missed-event bits through write-1 strobes.

Top module: `dtc_trigger_ctrl`

## Requirements
- R1: A hardware event pulse on a channel whose pending bit is clear sets that pending bit whatever the enable state; while the channel stays disabled the bit stays set and no transfer request is issued for it.
- R2: Setting the enable bit of a channel whose pending bit is set causes that channel to be queued and a transfer request to be issued for it.
- R3: A software set pulse on an idle channel queues it and leads to a transfer request even when its enable bit is clear.
- R4: When the FIFO head holds a channel with a valid descriptor (null flag 0), tr_valid_o is high with tr_chan_o equal to that channel number. On the handshake the pending bit clears, and a later trigger on that channel is served again.
- R5: When the FIFO head holds a channel with a null descriptor (null flag 1), no transfer request is offered for it. In the cycle it is removed from the FIFO, its pending bit clears and its missed-event bit is set.
- R6: A hardware event or software set that arrives while the channel's pending bit is still set is not queued again; the channel's missed-event bit is set and only one transfer request results.
- R7: When several channels become eligible together they enter the FIFO one per cycle, lowest channel number first, and their requests leave in that order.
- R8: The FIFO holds 16 channel numbers. While it is full, further eligible channels wait with their pending bits set, and every one of them is served once space frees up.
- R9: While tr_valid_o is high and tr_ready_i is low, tr_valid_o stays high and tr_chan_o stays unchanged in the next cycle.
- R10: A 1 on miss_clr_i clears the corresponding missed-event bit. If a miss is recorded for the same channel in the same cycle, the bit stays set.
- R11: A 1 on en_set_i sets the enable bit and a 1 on en_clr_i clears it. If both are 1 for the same channel, the bit ends up clear.
- R12: After reset, all pending, enable and missed-event bits read 0 and tr_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_evt_i | input | 32 | Hardware event pulses, one bit per channel |
| sw_set_i | input | 32 | Software set strobes, write-1 |
| en_set_i | input | 32 | Enable set strobes, write-1 |
| en_clr_i | input | 32 | Enable clear strobes, write-1 |
| miss_clr_i | input | 32 | Missed-event clear strobes, write-1 |
| desc_null_i | input | 32 | Per-channel null-descriptor flag (1 = null) |
| tr_ready_i | input | 1 | Transfer engine can accept a request |
| tr_valid_o | output | 1 | Transfer request offered |
| tr_chan_o | output | 5 | Channel number of the offered request |
| pend_o | output | 32 | Pending-event bits |
| en_o | output | 32 | Enable bits |
| miss_o | output | 32 | Missed-event bits |

## Verification
A table of single-channel cases crosses three inputs: the trigger source (hardware or software), the enable bit and the null flag. These cases separate the three outcomes: request issued, trigger dropped as a miss, and event left pending. The pending cases are then enabled to show they are served late.

Simultaneous triggers on several channels with ready held low check the lowest-first order and the stalled head. A burst on all 32 channels overfills the 16-entry queue and must still drain completely in order.

A repeated trigger during flight must raise a miss without producing a second request. A miss that collides with a clear must leave the bit set.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  // Action taken on the queue head in the current cycle
  typedef enum logic [1:0] {
    HEAD_EMPTY = 2'd0,
    HEAD_STALL = 2'd1,
    HEAD_ISSUE = 2'd2,
    HEAD_DROP  = 2'd3
  } head_act_e;
endpackage

// File: rtl/dtc_chan_state.sv
module dtc_chan_state #(
  parameter int NUM_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] hw_evt_i,
  input  logic [NUM_CH-1:0] sw_set_i,
  input  logic [NUM_CH-1:0] en_set_i,
  input  logic [NUM_CH-1:0] en_clr_i,
  input  logic [NUM_CH-1:0] miss_clr_i,
  input  logic [NUM_CH-1:0] enq_i,
  input  logic [NUM_CH-1:0] done_i,
  input  logic [NUM_CH-1:0] drop_i,
  output logic [NUM_CH-1:0] req_o,
  output logic [NUM_CH-1:0] pend_o,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] miss_o
);
  logic [NUM_CH-1:0] pend_q, pend_d;
  logic [NUM_CH-1:0] force_q, force_d;
  logic [NUM_CH-1:0] busy_q, busy_d;
  logic [NUM_CH-1:0] en_q, en_d;
  logic [NUM_CH-1:0] miss_q, miss_d;
  logic [NUM_CH-1:0] trig, fresh, again;

  always_comb begin
    trig    = hw_evt_i | sw_set_i;
    fresh   = trig & ~pend_q;
    again   = trig & pend_q;
    pend_d  = (pend_q & ~done_i) | fresh;
    force_d = (force_q & ~done_i) | (sw_set_i & ~pend_q);
    busy_d  = (busy_q & ~done_i) | enq_i;
    en_d    = (en_q | en_set_i) & ~en_clr_i;
    miss_d  = (miss_q & ~miss_clr_i) | again | drop_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      force_q <= '0;
      busy_q  <= '0;
      en_q    <= '0;
      miss_q  <= '0;
    end else begin
      pend_q  <= pend_d;
      force_q <= force_d;
      busy_q  <= busy_d;
      en_q    <= en_d;
      miss_q  <= miss_d;
    end
  end

  assign req_o  = pend_q & (en_q | force_q) & ~busy_q;
  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign miss_o = miss_q;

  // R1: a pending bit is only removed by a head evaluation
  p_pend_kept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(pend_q) & ~$past(done_i)) & ~pend_q) == '0));
  // R5: a dropped head always leaves its miss bit set
  p_drop_miss_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_i != '0) |=> (($past(drop_i) & ~miss_q) == '0));
  // R6: a trigger on a still-pending channel is recorded as missed
  p_again_miss_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((trig & pend_q) != '0) |=> (($past(trig & pend_q) & ~miss_q) == '0));
  // R6: the picker never enqueues a channel that is not requesting
  p_enq_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_i & ~req_o) == '0);
endmodule

// File: rtl/dtc_lowest_pick.sv
module dtc_lowest_pick #(
  parameter int NUM_CH = 32,
  localparam int CW = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic              allow_i,
  output logic [NUM_CH-1:0] grant_o,
  output logic [CW-1:0]     idx_o,
  output logic              any_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    any_o   = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = CW'(i);
        any_o = 1'b1;
      end
    end
    if (any_o && allow_i) grant_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/dtc_chan_fifo.sv
module dtc_chan_fifo #(
  parameter int W     = 5,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]   cnt_q, cnt_d;

  always_comb begin
    wr_d  = push_i ? AW'((32'(wr_q) + 1) % DEPTH) : wr_q;
    rd_d  = pop_i  ? AW'((32'(rd_q) + 1) % DEPTH) : rd_q;
    cnt_d = cnt_q + (AW+1)'(push_i) - (AW+1)'(pop_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));

  // R8: never written while full, never read while empty
  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/dtc_trigger_ctrl.sv
module dtc_trigger_ctrl #(
  parameter int NUM_CH  = 32,
  parameter int Q_DEPTH = 16,
  localparam int CW = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] hw_evt_i,
  input  logic [NUM_CH-1:0] sw_set_i,
  input  logic [NUM_CH-1:0] en_set_i,
  input  logic [NUM_CH-1:0] en_clr_i,
  input  logic [NUM_CH-1:0] miss_clr_i,
  input  logic [NUM_CH-1:0] desc_null_i,
  input  logic              tr_ready_i,
  output logic              tr_valid_o,
  output logic [CW-1:0]     tr_chan_o,
  output logic [NUM_CH-1:0] pend_o,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] miss_o
);
  import dtc_pkg::*;

  logic [NUM_CH-1:0] req, grant, done_mask, drop_mask;
  logic [CW-1:0]     pick_idx, head;
  logic              pick_any, q_empty, q_full, q_push, q_pop;
  head_act_e         act;

  dtc_chan_state #(.NUM_CH(NUM_CH)) u_state (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hw_evt_i(hw_evt_i), .sw_set_i(sw_set_i),
    .en_set_i(en_set_i), .en_clr_i(en_clr_i), .miss_clr_i(miss_clr_i),
    .enq_i(grant), .done_i(done_mask), .drop_i(drop_mask),
    .req_o(req), .pend_o(pend_o), .en_o(en_o), .miss_o(miss_o)
  );

  dtc_lowest_pick #(.NUM_CH(NUM_CH)) u_pick (
    .req_i(req), .allow_i(!q_full),
    .grant_o(grant), .idx_o(pick_idx), .any_o(pick_any)
  );

  assign q_push = pick_any && !q_full;

  dtc_chan_fifo #(.W(CW), .DEPTH(Q_DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(q_push), .data_i(pick_idx), .pop_i(q_pop),
    .head_o(head), .empty_o(q_empty), .full_o(q_full)
  );

  always_comb begin
    if (q_empty)                act = HEAD_EMPTY;
    else if (desc_null_i[head]) act = HEAD_DROP;
    else if (tr_ready_i)        act = HEAD_ISSUE;
    else                        act = HEAD_STALL;
    q_pop     = (act == HEAD_ISSUE) || (act == HEAD_DROP);
    done_mask = '0;
    drop_mask = '0;
    if (q_pop)             done_mask[head] = 1'b1;
    if (act == HEAD_DROP)  drop_mask[head] = 1'b1;
  end

  assign tr_valid_o = (act == HEAD_ISSUE) || (act == HEAD_STALL);
  assign tr_chan_o  = head;

  // R9: a stalled request is held unchanged
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tr_valid_o && !tr_ready_i) |=> (tr_valid_o && $stable(tr_chan_o)));
  // R5: no request is ever offered for a null descriptor
  p_valid_nonnull_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tr_valid_o |-> !desc_null_i[tr_chan_o]);
  // R7: at most one channel is enqueued per cycle
  p_one_enq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
endmodule

// File: tb/tb_dtc_trigger_ctrl.sv
`timescale 1ns/1ps
module tb_dtc_trigger_ctrl;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] hw_evt, sw_set, en_set, en_clr, miss_clr, dnull;
  logic tr_ready, tr_valid;
  logic [4:0] tr_chan;
  logic [N-1:0] pend, en, miss;

  always #2.5 clk = ~clk;

  dtc_trigger_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .hw_evt_i(hw_evt), .sw_set_i(sw_set),
    .en_set_i(en_set), .en_clr_i(en_clr), .miss_clr_i(miss_clr),
    .desc_null_i(dnull), .tr_ready_i(tr_ready), .tr_valid_o(tr_valid),
    .tr_chan_o(tr_chan), .pend_o(pend), .en_o(en), .miss_o(miss)
  );

  int checks = 0, fails = 0, acc_n = 0;
  int acc_log [256];
  bit done = 0;

  // accepted requests, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && tr_valid && tr_ready) begin
      if (acc_n < 256) acc_log[acc_n] = int'(tr_chan);
      acc_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic idle_inputs();
    hw_evt = '0; sw_set = '0; en_set = '0; en_clr = '0; miss_clr = '0;
  endtask

  // fields: [10:6] channel, [5] software, [4] enable, [3] null,
  //         [2] expect request, [1] expect miss, [0] expect pending left
  localparam logic [10:0] VEC [8] = '{
    {5'd3,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {5'd4,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {5'd6,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {5'd10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {5'd12, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {5'd31, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {5'd0,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {5'd20, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    dnull = '0; tr_ready = 1'b1; rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R12 reset state
    chk(pend == '0, "R12 pend", int'(pend), 0);
    chk(en == '0, "R12 en", int'(en), 0);
    chk(miss == '0, "R12 miss", int'(miss), 0);
    chk(!tr_valid, "R12 tr_valid", int'(tr_valid), 0);

    // table walk: R1 R3 R4 R5, then R2 for events left pending
    for (int v = 0; v < 8; v++) begin
      automatic int ch = int'(VEC[v][10:6]);
      automatic int base = acc_n;
      if (VEC[v][4]) en_set[ch] = 1'b1; else en_clr[ch] = 1'b1;
      dnull[ch] = VEC[v][3];
      step(1); idle_inputs();
      if (VEC[v][5]) sw_set[ch] = 1'b1; else hw_evt[ch] = 1'b1;
      step(1); idle_inputs();
      step(6);
      chk((acc_n - base) == int'(VEC[v][2]), "R4 request count", acc_n - base, int'(VEC[v][2]));
      if (VEC[v][2] && acc_n > base)
        chk(acc_log[base] == ch, "R4 channel", acc_log[base], ch);
      chk(miss[ch] == VEC[v][1], "R5 miss", int'(miss[ch]), int'(VEC[v][1]));
      chk(pend[ch] == VEC[v][0], "R1 pend", int'(pend[ch]), int'(VEC[v][0]));
      if (VEC[v][0]) begin
        base = acc_n;
        dnull[ch] = 1'b0; en_set[ch] = 1'b1;
        step(1); idle_inputs(); step(6);
        chk((acc_n - base) == 1 && acc_log[base] == ch, "R2 late service", acc_n - base, 1);
        chk(pend[ch] == 1'b0, "R2 pend cleared", int'(pend[ch]), 0);
      end
      miss_clr = '1; en_clr = '1; dnull = '0;
      step(1); idle_inputs(); step(1);
    end

    // R4: channel 3 can be triggered again after service
    begin
      automatic int base = acc_n;
      en_set[3] = 1'b1; step(1); idle_inputs();
      hw_evt[3] = 1'b1; step(1); idle_inputs(); step(6);
      chk((acc_n - base) == 1 && acc_log[base] == 3, "R4 retrigger served", acc_n - base, 1);
      chk(miss[3] == 1'b0, "R4 no miss", int'(miss[3]), 0);
    end

    // R7 / R9: simultaneous events, ready held low
    begin
      automatic int base = acc_n;
      tr_ready = 1'b0;
      en_set[2] = 1'b1; en_set[5] = 1'b1; en_set[9] = 1'b1;
      step(1); idle_inputs();
      hw_evt[9] = 1'b1; hw_evt[2] = 1'b1; hw_evt[5] = 1'b1;
      step(1); idle_inputs(); step(5);
      chk(tr_valid && tr_chan == 5'd2, "R9 stalled head", int'(tr_chan), 2);
      step(4);
      chk(tr_valid && tr_chan == 5'd2, "R9 head held", int'(tr_chan), 2);
      tr_ready = 1'b1; step(6);
      chk((acc_n - base) == 3, "R7 count", acc_n - base, 3);
      chk(acc_log[base] == 2 && acc_log[base+1] == 5 && acc_log[base+2] == 9,
          "R7 order", acc_log[base+1], 5);
      en_clr = '1; step(1); idle_inputs();
    end

    // R6: hardware and software retrigger while in flight
    begin
      automatic int base = acc_n;
      tr_ready = 1'b0;
      en_set[7] = 1'b1; step(1); idle_inputs();
      hw_evt[7] = 1'b1; step(1); idle_inputs(); step(3);
      hw_evt[7] = 1'b1; step(1); idle_inputs();
      chk(miss[7] == 1'b1, "R6 hw miss", int'(miss[7]), 1);
      sw_set[8] = 1'b1; step(1); idle_inputs(); step(1);
      sw_set[8] = 1'b1; step(1); idle_inputs();
      chk(miss[8] == 1'b1, "R6 sw miss", int'(miss[8]), 1);
      tr_ready = 1'b1; step(8);
      chk((acc_n - base) == 2, "R6 single request each", acc_n - base, 2);
      miss_clr = '1; en_clr = '1; step(1); idle_inputs();
    end

    // R10: miss and clear in the same cycle
    tr_ready = 1'b0;
    en_set[11] = 1'b1; step(1); idle_inputs();
    hw_evt[11] = 1'b1; step(1); idle_inputs(); step(2);
    hw_evt[11] = 1'b1; miss_clr[11] = 1'b1; step(1); idle_inputs();
    chk(miss[11] == 1'b1, "R10 set wins", int'(miss[11]), 1);
    miss_clr[11] = 1'b1; step(1); idle_inputs();
    chk(miss[11] == 1'b0, "R10 cleared", int'(miss[11]), 0);
    tr_ready = 1'b1; step(5);
    en_clr = '1; step(1); idle_inputs();

    // R11: enable set/clear priority
    en_set[14] = 1'b1; en_clr[14] = 1'b1; step(1); idle_inputs();
    chk(en[14] == 1'b0, "R11 clear wins", int'(en[14]), 0);
    en_set[14] = 1'b1; step(1); idle_inputs();
    chk(en[14] == 1'b1, "R11 set", int'(en[14]), 1);
    en_clr[14] = 1'b1; step(1); idle_inputs();
    chk(en[14] == 1'b0, "R11 clr", int'(en[14]), 0);

    // R8: all channels at once overfill the queue
    begin
      automatic int base = acc_n;
      automatic bit ordered = 1'b1;
      tr_ready = 1'b0;
      en_set = '1; step(1); idle_inputs();
      hw_evt = '1; step(1); idle_inputs(); step(40);
      chk(pend == '1, "R8 all pending", $countones(pend), N);
      tr_ready = 1'b1; step(80);
      chk((acc_n - base) == N, "R8 all served", acc_n - base, N);
      for (int k = 0; k < N; k++)
        if (base + k < 256 && acc_log[base + k] != k) ordered = 1'b0;
      chk(ordered, "R8 drain order", int'(ordered), 1);
      chk(pend == '0 && miss == '0, "R8 clean", int'(miss), 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule